// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard and Forwarding Controller

This block is the hazard control for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory access and write-back. The datapath hands it the decode-stage instruction word, that instruction's control flags and destination register, and the result values held in the memory-stage and write-back-stage pipeline registers. The block keeps its own small record of which destination registers are in flight in execute, memory and write-back.

From this record it produces three things. The first is the forwarding-mux selects for the two execute operands, registered so that they line up with the instruction as it enters execute. The second is a hold for the fetch PC and the decode register, together with a bubble request for execute. The third is the next fetch PC. Branches test one register for zero or non-zero in decode, using a dedicated target adder there.

The design has exactly one architectural delay slot. The instruction fetched while a branch sits in decode always completes, and a taken branch redirects the fetch that follows it. Nothing is ever squashed. The register file is read only in decode and written only in write-back, so only read-after-write hazards are tracked.

Top module: `hz_ctrl`

## Requirements
- R1: After synchronous reset, `fetch_pc` equals the reset PC, `hold_fd`, `ex_bubble` and `br_taken` are low, and both forwarding selects are 0. Select codes are 0 for the register file, 1 for the memory-stage ALU result and 2 for the write-back result.
- R2: If the instruction in execute writes a register that a used source of the decode instruction names, that operand's select becomes 1 on the next clock. Source A is instruction bits 25:21 and source B is bits 20:16.
- R3: If the match is instead with the instruction in the memory stage, the select becomes 2 on the next clock.
- R4: When both the execute and memory stages write the named register, the execute-stage producer wins and the select is 1.
- R5: A destination of register 0 is never forwarded and never causes a stall, for ALU operands or for branches.
- R6: A load in execute whose destination is a used source of the decode instruction raises `hold_fd` and `ex_bubble` for exactly one cycle. The retried instruction then gets select 2 for that operand.
- R7: A source whose use flag is low neither stalls nor forwards, even if its register number matches a producer.
- R8: During a hold, `fetch_pc` keeps its value, and the selects registered at that edge are 0 because execute receives a bubble.
- R9: A decode branch tests source A for zero (`id_br_if_zero` high) or non-zero (low). When the test holds, `br_taken` is high and the next `fetch_pc` is decode PC + 4 + (sign-extended bits 15:0 shifted left by 2). The delay-slot fetch in progress is not cancelled.
- R10: The branch operand comes from the memory-stage ALU result if that stage writes the register, otherwise from the write-back value if that stage does, otherwise from the register file.
- R11: A branch whose register is written by the instruction in execute holds decode one cycle. If that producer is a load, decode holds two cycles.
- R12: While held, a branch is never taken. A branch that is not taken, like any unheld cycle, advances `fetch_pc` by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_insn | input | 32 | Decode instruction word |
| id_pc | input | 32 | PC of the decode instruction |
| id_use_a | input | 1 | Decode instruction reads source A |
| id_use_b | input | 1 | Decode instruction reads source B |
| id_wr_en | input | 1 | Decode instruction writes a register |
| id_wr_reg | input | 5 | Destination register of the decode instruction |
| id_is_load | input | 1 | Decode instruction is a load |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_if_zero | input | 1 | Branch taken on zero (1) or on non-zero (0) |
| rf_a_data | input | 32 | Register file read value for source A |
| mem_alu_data | input | 32 | ALU result held in the memory stage |
| wb_data | input | 32 | Value being written back |
| fetch_pc | output | 32 | Current fetch PC |
| hold_fd | output | 1 | Hold fetch PC and decode register |
| ex_bubble | output | 1 | Load a no-operation into execute |
| ex_fwd_a | output | 2 | Registered forwarding select, operand A |
| ex_fwd_b | output | 2 | Registered forwarding select, operand B |
| br_taken | output | 1 | Decode branch is taken this cycle |

## Verification
The hardest condition to reach from the ports is a branch whose register is produced by a load directly ahead of it. It needs a two-cycle hold, after which the value must come from the write-back path rather than from a stale register file or memory-stage value. The stimulus drains the pipeline with idle cycles and issues the load. It then presents the branch and keeps it in decode for as long as `hold_fd` is expected to be high. During the hold it drives different values on the three operand sources, so only the write-back value can yield a taken branch. The same retry pattern covers the ALU-load interlock and the execute-producer branch stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int REG_AW = 5;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;

  typedef struct packed {
    logic              wen;
    logic              load;
    logic [REG_AW-1:0] rd;
  } dst_t;
endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bubble,
  input  logic              id_valid,
  input  logic              id_wen,
  input  logic              id_load,
  input  logic [REG_AW-1:0] id_rd,
  output dst_t              ex_dst,
  output dst_t              mem_dst,
  output dst_t              wb_dst
);
  dst_t id_dst;

  always_comb begin
    id_dst.wen  = id_valid && id_wen && !bubble;
    id_dst.load = id_valid && id_load && id_wen && !bubble;
    id_dst.rd   = id_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_dst  <= '0;
      mem_dst <= '0;
      wb_dst  <= '0;
    end else begin
      ex_dst  <= id_dst;
      mem_dst <= ex_dst;
      wb_dst  <= mem_dst;
    end
  end

  // R8: a bubble never reaches execute as a register writer
  a_r8_bubble_no_write: assert property (@(posedge clk) disable iff (rst)
    bubble |=> !ex_dst.wen);
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              src_used,
  input  logic [REG_AW-1:0] src,
  input  dst_t              ex_dst,
  input  dst_t              mem_dst,
  output logic [1:0]        sel
);
  fwd_sel_e nxt;

  always_comb begin
    nxt = FWD_RF;
    if (take && src_used && src != '0) begin
      if (ex_dst.wen && ex_dst.rd == src)
        nxt = FWD_MEM;
      else if (mem_dst.wen && mem_dst.rd == src)
        nxt = FWD_WB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel <= 2'(FWD_RF);
    else     sel <= 2'(nxt);
  end

  // R8: no forwarding is registered for a bubble or an idle slot
  a_r8_idle_sel_rf: assert property (@(posedge clk) disable iff (rst)
    !take |=> sel == 2'(FWD_RF));
  // R1: select stays within the three defined codes
  a_r1_sel_code_legal: assert property (@(posedge clk) disable iff (rst)
    sel != 2'd3);
endmodule

// File: rtl/hz_branch.sv
module hz_branch
  import hz_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic              id_is_branch,
  input  logic              if_zero,
  input  logic [XLEN-1:0]   id_pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [REG_AW-1:0] src,
  input  logic [XLEN-1:0]   rf_data,
  input  logic [XLEN-1:0]   mem_alu_data,
  input  logic [XLEN-1:0]   wb_data,
  input  dst_t              mem_dst,
  input  dst_t              wb_dst,
  output logic              cond_met,
  output logic [XLEN-1:0]   target
);
  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] opnd;
  logic [XLEN-1:0] offs;

  always_comb begin
    if (src != '0 && mem_dst.wen && !mem_dst.load && mem_dst.rd == src)
      opnd = mem_alu_data;
    else if (src != '0 && wb_dst.wen && wb_dst.rd == src)
      opnd = wb_data;
    else
      opnd = rf_data;
  end

  assign offs     = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign target   = id_pc + XLEN'(4) + offs;
  assign cond_met = id_is_branch && (if_zero ? (opnd == '0) : (opnd != '0));

  // R5: register zero is never taken from a bypass path
  always_comb begin
    if (src == '0)
      a_r5_zero_from_rf: assert (opnd == rf_data);
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] PC_RESET = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        id_valid,
  input  logic [31:0] id_insn,
  input  logic [31:0] id_pc,
  input  logic        id_use_a,
  input  logic        id_use_b,
  input  logic        id_wr_en,
  input  logic [4:0]  id_wr_reg,
  input  logic        id_is_load,
  input  logic        id_is_branch,
  input  logic        id_br_if_zero,
  input  logic [31:0] rf_a_data,
  input  logic [31:0] mem_alu_data,
  input  logic [31:0] wb_data,
  output logic [31:0] fetch_pc,
  output logic        hold_fd,
  output logic        ex_bubble,
  output logic [1:0]  ex_fwd_a,
  output logic [1:0]  ex_fwd_b,
  output logic        br_taken
);
  localparam int SRC_A_LSB = 21;
  localparam int SRC_B_LSB = 16;
  localparam int IMM_W     = 16;
  localparam int NSRC      = 2;

  dst_t ex_dst, mem_dst, wb_dst;
  logic [REG_AW-1:0] src [NSRC];
  logic [NSRC-1:0]   used;
  logic [1:0]        sel [NSRC];
  logic [NSRC-1:0]   load_hit;
  logic              br_ex_hit, br_load_hit;
  logic              cond_met;
  logic [XLEN-1:0]   br_target;

  assign src[0]  = id_insn[SRC_A_LSB +: REG_AW];
  assign src[1]  = id_insn[SRC_B_LSB +: REG_AW];
  assign used[0] = id_use_a;
  assign used[1] = id_use_b;

  // load-use interlock per source
  for (genvar g = 0; g < NSRC; g++) begin : g_load_hit
    assign load_hit[g] = used[g] && src[g] != '0 &&
                         ex_dst.load && ex_dst.rd == src[g];
  end

  // branch interlocks: any producer in execute, or a load in memory
  assign br_ex_hit   = id_is_branch && src[0] != '0 &&
                       ex_dst.wen && ex_dst.rd == src[0];
  assign br_load_hit = id_is_branch && src[0] != '0 &&
                       mem_dst.load && mem_dst.rd == src[0];

  assign hold_fd   = id_valid && (|load_hit || br_ex_hit || br_load_hit);
  assign ex_bubble = hold_fd;

  hz_stage_track u_track (
    .clk      (clk),
    .rst      (rst),
    .bubble   (ex_bubble),
    .id_valid (id_valid),
    .id_wen   (id_wr_en),
    .id_load  (id_is_load),
    .id_rd    (id_wr_reg),
    .ex_dst   (ex_dst),
    .mem_dst  (mem_dst),
    .wb_dst   (wb_dst)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    hz_fwd_unit u_fwd (
      .clk      (clk),
      .rst      (rst),
      .take     (id_valid && !hold_fd),
      .src_used (used[g]),
      .src      (src[g]),
      .ex_dst   (ex_dst),
      .mem_dst  (mem_dst),
      .sel      (sel[g])
    );
  end

  assign ex_fwd_a = sel[0];
  assign ex_fwd_b = sel[1];

  hz_branch #(.XLEN(XLEN), .IMM_W(IMM_W)) u_branch (
    .id_is_branch (id_valid && id_is_branch),
    .if_zero      (id_br_if_zero),
    .id_pc        (id_pc),
    .imm          (id_insn[IMM_W-1:0]),
    .src          (src[0]),
    .rf_data      (rf_a_data),
    .mem_alu_data (mem_alu_data),
    .wb_data      (wb_data),
    .mem_dst      (mem_dst),
    .wb_dst       (wb_dst),
    .cond_met     (cond_met),
    .target       (br_target)
  );

  assign br_taken = cond_met && !hold_fd;

  always_ff @(posedge clk) begin
    if (rst)            fetch_pc <= PC_RESET;
    else if (hold_fd)   fetch_pc <= fetch_pc;
    else if (br_taken)  fetch_pc <= br_target;
    else                fetch_pc <= fetch_pc + 32'd4;
  end

  // R8: fetch PC frozen across a hold
  a_r8_hold_keeps_pc: assert property (@(posedge clk) disable iff (rst)
    hold_fd |=> $stable(fetch_pc));
  // R9: taken branch redirects the fetch after the delay slot
  a_r9_taken_redirect: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> fetch_pc == $past(br_target));
  // R12: an unheld, untaken cycle steps the PC by one word
  a_r12_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!hold_fd && !br_taken) |=> fetch_pc == $past(fetch_pc) + 32'd4);
  // R6: a load-use stall lasts a single cycle when no branch is involved
  a_r6_single_stall: assert property (@(posedge clk) disable iff (rst)
    (hold_fd && !id_is_branch && $past(!hold_fd)) |=> !(hold_fd && $stable(id_insn) && !id_is_branch));
endmodule

// File: tb/hz_ctrl_tb_top.sv
module hz_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        id_valid = 1'b0;
  logic [31:0] id_insn = '0;
  logic [31:0] id_pc = '0;
  logic        id_use_a = 1'b0, id_use_b = 1'b0, id_wr_en = 1'b0;
  logic [4:0]  id_wr_reg = '0;
  logic        id_is_load = 1'b0, id_is_branch = 1'b0, id_br_if_zero = 1'b0;
  logic [31:0] rf_a_data = '0, mem_alu_data = '0, wb_data = '0;
  logic [31:0] fetch_pc;
  logic        hold_fd, ex_bubble, br_taken;
  logic [1:0]  ex_fwd_a, ex_fwd_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hz_ctrl dut_i (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_insn(id_insn), .id_pc(id_pc),
    .id_use_a(id_use_a), .id_use_b(id_use_b), .id_wr_en(id_wr_en),
    .id_wr_reg(id_wr_reg), .id_is_load(id_is_load), .id_is_branch(id_is_branch),
    .id_br_if_zero(id_br_if_zero), .rf_a_data(rf_a_data),
    .mem_alu_data(mem_alu_data), .wb_data(wb_data), .fetch_pc(fetch_pc),
    .hold_fd(hold_fd), .ex_bubble(ex_bubble), .ex_fwd_a(ex_fwd_a),
    .ex_fwd_b(ex_fwd_b), .br_taken(br_taken)
  );

  typedef struct packed {
    logic       v;
    logic [4:0] ra;
    logic [4:0] rb;
    logic       ua;
    logic       ub;
    logic       we;
    logic [4:0] rd;
    logic       ld;
    logic       eh;
    logic [1:0] efa;
    logic [1:0] efb;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 5'd2,  5'd3,  1'b1, 1'b1, 1'b1, 5'd1,  1'b0, 1'b0, 2'd0, 2'd0},
    '{1'b1, 5'd1,  5'd3,  1'b1, 1'b1, 1'b1, 5'd4,  1'b0, 1'b0, 2'd1, 2'd0},
    '{1'b1, 5'd1,  5'd7,  1'b1, 1'b1, 1'b1, 5'd6,  1'b0, 1'b0, 2'd2, 2'd0},
    '{1'b1, 5'd4,  5'd1,  1'b1, 1'b1, 1'b1, 5'd6,  1'b0, 1'b0, 2'd2, 2'd0},
    '{1'b1, 5'd6,  5'd6,  1'b1, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 2'd1, 2'd1},
    '{1'b1, 5'd0,  5'd0,  1'b1, 1'b1, 1'b1, 5'd9,  1'b0, 1'b0, 2'd0, 2'd0},
    '{1'b1, 5'd2,  5'd0,  1'b1, 1'b0, 1'b1, 5'd10, 1'b1, 1'b0, 2'd0, 2'd0},
    '{1'b1, 5'd10, 5'd11, 1'b1, 1'b1, 1'b1, 5'd12, 1'b0, 1'b1, 2'd0, 2'd0},
    '{1'b1, 5'd10, 5'd11, 1'b1, 1'b1, 1'b1, 5'd12, 1'b0, 1'b0, 2'd2, 2'd0},
    '{1'b1, 5'd2,  5'd0,  1'b1, 1'b0, 1'b1, 5'd0,  1'b1, 1'b0, 2'd0, 2'd0},
    '{1'b1, 5'd0,  5'd0,  1'b1, 1'b1, 1'b1, 5'd15, 1'b0, 1'b0, 2'd0, 2'd0},
    '{1'b1, 5'd2,  5'd0,  1'b1, 1'b0, 1'b1, 5'd13, 1'b1, 1'b0, 2'd0, 2'd0},
    '{1'b1, 5'd13, 5'd13, 1'b0, 1'b0, 1'b1, 5'd14, 1'b0, 1'b0, 2'd0, 2'd0},
    '{1'b1, 5'd5,  5'd13, 1'b1, 1'b1, 1'b1, 5'd16, 1'b0, 1'b0, 2'd0, 2'd2}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:  return "R2";
      1:  return "R2";
      2:  return "R3";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      7:  return "R6";
      8:  return "R6";
      10: return "R5";
      12: return "R7";
      13: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_op(input logic [4:0] ra, input logic [4:0] rb,
                        input logic ua, input logic ub, input logic we,
                        input logic [4:0] rd, input logic ld);
    id_valid = 1'b1; id_is_branch = 1'b0;
    id_insn = {6'd0, ra, rb, 16'd0};
    id_use_a = ua; id_use_b = ub; id_wr_en = we; id_wr_reg = rd; id_is_load = ld;
  endtask

  task automatic set_br(input logic [4:0] ra, input logic if_zero,
                        input logic [31:0] pc, input logic [15:0] imm);
    id_valid = 1'b1; id_is_branch = 1'b1; id_br_if_zero = if_zero;
    id_insn = {6'd4, ra, 5'd0, imm}; id_pc = pc;
    id_use_a = 1'b1; id_use_b = 1'b0; id_wr_en = 1'b0; id_wr_reg = '0; id_is_load = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      id_valid = 1'b0; id_is_branch = 1'b0; id_wr_en = 1'b0; id_is_load = 1'b0;
    end
  endtask

  // one branch cycle: check comb outputs, then PC after the edge
  task automatic br_cycle(input string req, input logic exp_hold,
                          input logic exp_taken, input logic [31:0] exp_pc_delta,
                          input logic use_target, input logic [31:0] target);
    logic [31:0] p;
    #1;
    p = fetch_pc;
    chk(req, "hold_fd", 32'(hold_fd), 32'(exp_hold));
    chk(req, "br_taken", 32'(br_taken), 32'(exp_taken));
    @(posedge clk); #1;
    chk(req, "fetch_pc", fetch_pc, use_target ? target : p + exp_pc_delta);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "fetch_pc", fetch_pc, 32'h0);
    chk("R1", "hold_fd", 32'(hold_fd), 32'h0);
    chk("R1", "ex_bubble", 32'(ex_bubble), 32'h0);
    chk("R1", "br_taken", 32'(br_taken), 32'h0);
    chk("R1", "ex_fwd_a", 32'(ex_fwd_a), 32'h0);
    chk("R1", "ex_fwd_b", 32'(ex_fwd_b), 32'h0);

    // vector table: ALU forwarding, priority, r0, load-use, unused sources
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      set_op(VEC[i].ra, VEC[i].rb, VEC[i].ua, VEC[i].ub, VEC[i].we, VEC[i].rd, VEC[i].ld);
      #1;
      chk(vec_tag(i), "hold_fd", 32'(hold_fd), 32'(VEC[i].eh));
      chk(vec_tag(i), "ex_bubble", 32'(ex_bubble), 32'(VEC[i].eh));
      @(posedge clk); #1;
      chk(VEC[i].eh ? "R8" : vec_tag(i), "ex_fwd_a", 32'(ex_fwd_a), 32'(VEC[i].efa));
      chk(VEC[i].eh ? "R8" : vec_tag(i), "ex_fwd_b", 32'(ex_fwd_b), 32'(VEC[i].efb));
    end

    // R9: beqz taken from register file, positive offset
    idle(4);
    @(negedge clk);
    set_br(5'd5, 1'b1, 32'h100, 16'h0004); rf_a_data = 32'd0;
    br_cycle("R9", 1'b0, 1'b1, 32'd0, 1'b1, 32'h114);
    // R12: bnez on zero is not taken, PC steps by 4
    @(negedge clk);
    set_br(5'd5, 1'b0, 32'h104, 16'h0004); rf_a_data = 32'd0;
    br_cycle("R12", 1'b0, 1'b0, 32'd4, 1'b0, 32'h0);
    // R9: bnez taken, negative offset
    @(negedge clk);
    set_br(5'd5, 1'b0, 32'h180, 16'hFFFE); rf_a_data = 32'd3;
    br_cycle("R9", 1'b0, 1'b1, 32'd0, 1'b1, 32'h17C);

    // R11/R10: ALU producer in execute, one stall then memory-stage bypass
    idle(4);
    @(negedge clk);
    set_op(5'd1, 5'd2, 1'b1, 1'b1, 1'b1, 5'd5, 1'b0);
    @(negedge clk);
    set_br(5'd5, 1'b1, 32'h200, 16'h0008);
    rf_a_data = 32'd7; mem_alu_data = 32'd0; wb_data = 32'd7;
    br_cycle("R11", 1'b1, 1'b0, 32'd0, 1'b0, 32'h0);
    @(negedge clk);
    br_cycle("R10", 1'b0, 1'b1, 32'd0, 1'b1, 32'h224);

    // R11/R10: load ahead of branch, two stalls then write-back bypass
    idle(4);
    @(negedge clk);
    set_op(5'd1, 5'd0, 1'b1, 1'b0, 1'b1, 5'd5, 1'b1);
    @(negedge clk);
    set_br(5'd5, 1'b1, 32'h300, 16'hFFFF);
    rf_a_data = 32'd9; mem_alu_data = 32'd9; wb_data = 32'd0;
    br_cycle("R11", 1'b1, 1'b0, 32'd0, 1'b0, 32'h0);
    @(negedge clk);
    br_cycle("R11", 1'b1, 1'b0, 32'd0, 1'b0, 32'h0);
    @(negedge clk);
    br_cycle("R10", 1'b0, 1'b1, 32'd0, 1'b1, 32'h300);

    // R5: producer of r0 in execute does not stall a branch on r0
    idle(4);
    @(negedge clk);
    set_op(5'd1, 5'd2, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0);
    @(negedge clk);
    set_br(5'd0, 1'b0, 32'h400, 16'h0010);
    rf_a_data = 32'd0; mem_alu_data = 32'd5; wb_data = 32'd5;
    br_cycle("R5", 1'b0, 1'b0, 32'd4, 1'b0, 32'h0);

    idle(1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule